// File: doc/BRIEF.md
# Indexed Clock Register Port with Interrupt Flags

This block is the host-facing access point of a real-time clock. It holds a 128-byte space of clock, control and general-purpose bytes behind a two-address window. A write to the even address selects a byte. Accesses to the odd address then read or write the selected byte. The block owns the control bytes at indices 0x0A (rate control) and 0x0B (enables). It also owns the interrupt flag byte at 0x0C and the status byte at 0x0D. It drives an active-high interrupt request.

The timekeeping and periodic counters live in neighbouring blocks. They report events through three one-cycle flag-set inputs. This block merges those events into the flag byte and applies the enable rules in the enable byte. A read of the flag byte clears it. The enable byte's bits 6:4 are the periodic, alarm and update enables, matching flag bits 6:4.

The block has two reset inputs. `rst` is the power-up initialisation. `sys_rst` is a warm system reset, which keeps most of the contents.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even address (`bus_odd`=0) stores `bus_wdata[6:0]` as the index; a read of the even address returns 0xFF.
- R2: A write to the odd address stores the byte at the current index, and a read of the odd address returns it. Indices other than 0x0A to 0x0D act as plain storage.
- R3: Writes to index 0x0C (flags) and 0x0D (status) have no effect; the status byte always reads 0x80.
- R4: A read of index 0x0C returns the flag byte and, in the following cycle, the byte is zero and `irq` is low.
- R5: `evt_periodic`, `evt_alarm` and `evt_update` set flag bits 6, 5 and 4. Flag bit 7 is the request flag, and `irq` follows it.
- R6: An event raises the request only if its flag bit was clear before the event and the matching enable bit (enable byte bit 6, 5 or 4) is set.
- R7: A write to index 0x0B sets the request when the written enables select a pending flag, and clears the request otherwise. The flags themselves are kept.
- R8: After `rst`, the rate byte reads 0x26, the enable byte 0x02, the flag byte 0x00, the status byte 0x80 and every storage byte 0x00; `irq` is low.
- R9: `sys_rst` clears enable bits 6, 5 and 3, keeps the other enable bits, clears the flag byte and drops `irq`.
- R10: `sys_rst` sets the byte at index 0x0F to 0x00 unless it holds 0xFE, and leaves other storage bytes unchanged.
- R11: An event that arrives in the same cycle as a flag-byte read is not lost: it appears in the flag byte after the clear and raises the request under R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-up reset, active high |
| sys_rst | input | 1 | Synchronous warm system reset, active high |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_odd | input | 1 | Address bit 0: 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read strobe |
| evt_periodic | input | 1 | Periodic event pulse from the rate divider |
| evt_alarm | input | 1 | Alarm match pulse from the timekeeper |
| evt_update | input | 1 | Update-ended pulse from the timekeeper |
| ctl_rate | output | 8 | Current rate control byte, for the timing blocks |
| ctl_enable | output | 8 | Current enable byte, for the timing blocks |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest cases come from same-cycle collisions. One is an event arriving in the cycle the host reads the flag byte. Another is an enable written while a flag is already pending. To reach them, the bench drives an event pulse in the same cycle as the read strobe. It then checks both the returned old value and the flag byte that follows.

A second hard case is a flag that sits pending with its enable off and then gets enabled. The bench leaves the enable off, lets the event set the flag, and confirms no request. It then writes the enable byte to trigger the immediate request. After that, it writes a different enable set to show the request clears while the flag stays readable.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
    localparam int DW = 8;
    localparam int AW = 7;
    localparam int DEPTH = 1 << AW;

    localparam logic [AW-1:0] IX_RATE   = 7'h0A;
    localparam logic [AW-1:0] IX_ENABLE = 7'h0B;
    localparam logic [AW-1:0] IX_FLAGS  = 7'h0C;
    localparam logic [AW-1:0] IX_STATUS = 7'h0D;
    localparam logic [AW-1:0] IX_BOOT   = 7'h0F;

    localparam logic [DW-1:0] RATE_INIT   = 8'h26;
    localparam logic [DW-1:0] ENABLE_INIT = 8'h02;
    localparam logic [DW-1:0] STATUS_VAL  = 8'h80;
    localparam logic [DW-1:0] BOOT_KEEP   = 8'hFE;
    localparam logic [DW-1:0] WARM_CLR    = 8'h68;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_RATE, SEL_ENABLE, SEL_FLAGS, SEL_STATUS, SEL_RAM
    } sel_e;

    typedef struct packed {
        logic            rd;
        logic            wr;
        sel_e            sel;
        logic [DW-1:0]   wdata;
    } acc_t;

    function automatic sel_e decode(input logic [AW-1:0] ix);
        case (ix)
            IX_RATE:   return SEL_RATE;
            IX_ENABLE: return SEL_ENABLE;
            IX_FLAGS:  return SEL_FLAGS;
            IX_STATUS: return SEL_STATUS;
            default:   return SEL_RAM;
        endcase
    endfunction
endpackage

// File: rtl/rtcp_index.sv
module rtcp_index
    import rtcp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_en,
    input  logic          bus_wr,
    input  logic          bus_odd,
    input  logic [DW-1:0] bus_wdata,
    output logic [AW-1:0] index,
    output acc_t          acc
);
    logic [AW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (bus_en && bus_wr && !bus_odd)
            idx_q <= bus_wdata[AW-1:0];
    end

    always_comb begin
        acc.rd    = bus_en && !bus_wr && bus_odd;
        acc.wr    = bus_en &&  bus_wr && bus_odd;
        acc.sel   = (bus_en && bus_odd) ? decode(idx_q) : SEL_NONE;
        acc.wdata = bus_wdata;
    end

    assign index = idx_q;

    p_index_load_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_wr && !bus_odd) |=> (index == $past(bus_wdata[AW-1:0])));
endmodule

// File: rtl/rtcp_ram.sv
module rtcp_ram
    import rtcp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sys_rst,
    input  logic [AW-1:0] index,
    input  acc_t          acc,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (sys_rst) begin
            if (mem[IX_BOOT] != BOOT_KEEP) mem[IX_BOOT] <= '0;
        end else if (acc.wr && acc.sel == SEL_RAM) begin
            mem[index] <= acc.wdata;
        end
    end

    assign rdata = mem[index];

    p_boot_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (sys_rst && mem[IX_BOOT] == BOOT_KEEP) |=> (mem[IX_BOOT] == BOOT_KEEP));
    p_boot_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (sys_rst && mem[IX_BOOT] != BOOT_KEEP) |=> (mem[IX_BOOT] == '0));
endmodule

// File: rtl/rtcp_flags.sv
module rtcp_flags
    import rtcp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sys_rst,
    input  acc_t          acc,
    input  logic [2:0]    evt,
    output logic [DW-1:0] rate_q,
    output logic [DW-1:0] enable_q,
    output logic [DW-1:0] flags_q,
    output logic          irq
);
    logic          wr_rate, wr_en, rd_fl;
    logic [DW-1:0] fl_base, fl_next;
    logic [2:0]    fresh;

    assign wr_rate = acc.wr && acc.sel == SEL_RATE;
    assign wr_en   = acc.wr && acc.sel == SEL_ENABLE;
    assign rd_fl   = acc.rd && acc.sel == SEL_FLAGS;

    always_comb begin
        fl_base = rd_fl ? '0 : flags_q;
        fresh   = evt & ~fl_base[6:4];
        fl_next = fl_base;
        fl_next[6:4] = fl_base[6:4] | evt;
        if (wr_en)
            fl_next[7] = |(acc.wdata[6:4] & fl_next[6:4]);
        else
            fl_next[7] = fl_base[7] | |(fresh & enable_q[6:4]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q   <= RATE_INIT;
            enable_q <= ENABLE_INIT;
            flags_q  <= '0;
        end else if (sys_rst) begin
            enable_q <= enable_q & ~WARM_CLR;
            flags_q  <= '0;
        end else begin
            if (wr_rate) rate_q <= acc.wdata;
            if (wr_en)   enable_q <= acc.wdata;
            flags_q <= fl_next;
        end
    end

    assign irq = flags_q[7];

    p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_fl && evt == 3'b000) |=> (flags_q == '0 && !irq));
    p_only_new_enabled_r6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !flags_q[7] && (evt & ~flags_q[6:4] & enable_q[6:4]) == 3'b000)
        |=> !irq);
    p_new_enabled_raises_r6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !sys_rst && (evt & ~flags_q[6:4] & enable_q[6:4]) != 3'b000) |=> irq);
    p_enable_write_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sys_rst && !rd_fl && (acc.wdata[6:4] & flags_q[6:4]) != 3'b000) |=> irq);
    p_flags_ro_r3: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.sel == SEL_FLAGS && evt == 3'b000 && !sys_rst) |=> $stable(flags_q));
    p_warm_reset_r9: assert property (@(posedge clk) disable iff (rst)
        sys_rst |=> (flags_q == '0 && (enable_q & WARM_CLR) == '0));
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
    import rtcp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sys_rst,
    input  logic          bus_en,
    input  logic          bus_wr,
    input  logic          bus_odd,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          evt_periodic,
    input  logic          evt_alarm,
    input  logic          evt_update,
    output logic [7:0]    ctl_rate,
    output logic [7:0]    ctl_enable,
    output logic          irq
);
    logic [AW-1:0] index;
    acc_t          acc;
    logic [DW-1:0] ram_rd, flags_q;

    rtcp_index u_index (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_odd(bus_odd), .bus_wdata(bus_wdata), .index(index), .acc(acc)
    );

    rtcp_ram u_ram (
        .clk(clk), .rst(rst), .sys_rst(sys_rst), .index(index),
        .acc(acc), .rdata(ram_rd)
    );

    rtcp_flags u_flags (
        .clk(clk), .rst(rst), .sys_rst(sys_rst), .acc(acc),
        .evt({evt_periodic, evt_alarm, evt_update}),
        .rate_q(ctl_rate), .enable_q(ctl_enable), .flags_q(flags_q), .irq(irq)
    );

    always_comb begin
        if (!bus_odd) begin
            bus_rdata = 8'hFF;
        end else begin
            case (decode(index))
                SEL_RATE:   bus_rdata = ctl_rate;
                SEL_ENABLE: bus_rdata = ctl_enable;
                SEL_FLAGS:  bus_rdata = flags_q;
                SEL_STATUS: bus_rdata = STATUS_VAL;
                default:    bus_rdata = ram_rd;
            endcase
        end
    end

    p_even_read_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_wr && !bus_odd) |-> (bus_rdata == 8'hFF));
    p_status_const_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_wr && bus_odd && index == IX_STATUS) |-> (bus_rdata == STATUS_VAL));
endmodule

// File: tb/sim_rtc_regport.sv
module sim_rtc_regport;
    logic clk = 1'b0;
    logic rst = 1'b1, sys_rst = 1'b0;
    logic bus_en = 1'b0, bus_wr = 1'b0, bus_odd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata, ctl_rate, ctl_enable;
    logic evt_periodic = 1'b0, evt_alarm = 1'b0, evt_update = 1'b0;
    logic irq;
    int checks = 0, errors = 0;
    logic [7:0] d;

    always #10 clk = ~clk;

    rtc_regport u0 (
        .clk(clk), .rst(rst), .sys_rst(sys_rst), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_odd(bus_odd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
        .ctl_rate(ctl_rate), .ctl_enable(ctl_enable), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic odd, input logic [7:0] v);
        @(negedge clk);
        bus_en = 1; bus_wr = 1; bus_odd = odd; bus_wdata = v;
        @(posedge clk); #1 bus_en = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic odd, output logic [7:0] v);
        @(negedge clk);
        bus_en = 1; bus_wr = 0; bus_odd = odd;
        #1 v = bus_rdata;
        @(posedge clk); #1 bus_en = 0;
    endtask

    task automatic wr_ix(input logic [6:0] ix, input logic [7:0] v);
        wr(0, {1'b0, ix}); wr(1, v);
    endtask

    task automatic rd_ix(input logic [6:0] ix, output logic [7:0] v);
        wr(0, {1'b0, ix}); rd(1, v);
    endtask

    task automatic pulse(input logic p, input logic a, input logic u);
        @(negedge clk);
        evt_periodic = p; evt_alarm = a; evt_update = u;
        @(posedge clk); #1 {evt_periodic, evt_alarm, evt_update} = 3'b000;
    endtask

    task automatic warm();
        @(negedge clk); sys_rst = 1;
        @(posedge clk); #1 sys_rst = 0;
    endtask

    task automatic t_powerup();
        rd_ix(7'h0A, d); chk("R8 rate", d, 8'h26);
        rd_ix(7'h0B, d); chk("R8 enable", d, 8'h02);
        rd_ix(7'h0C, d); chk("R8 flags", d, 8'h00);
        rd_ix(7'h0D, d); chk("R8 status", d, 8'h80);
        rd_ix(7'h33, d); chk("R8 storage", d, 8'h00);
        chk("R8 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_index();
        wr(0, 8'hC5);
        rd(0, d); chk("R1 even read", d, 8'hFF);
        wr(1, 8'h5A);
        rd_ix(7'h45, d); chk("R1 index bits 6:0", d, 8'h5A);
    endtask

    task automatic t_storage();
        wr_ix(7'h10, 8'hA1); wr_ix(7'h7F, 8'h3C); wr_ix(7'h00, 8'h59);
        rd_ix(7'h10, d); chk("R2 byte 10", d, 8'hA1);
        rd_ix(7'h7F, d); chk("R2 byte 7F", d, 8'h3C);
        rd_ix(7'h00, d); chk("R2 byte 00", d, 8'h59);
        wr_ix(7'h0A, 8'h2F);
        rd_ix(7'h0A, d); chk("R2 rate write", d, 8'h2F);
    endtask

    task automatic t_readonly();
        pulse(0, 0, 1);
        wr_ix(7'h0C, 8'hFF);
        rd_ix(7'h0C, d); chk("R3 flags write ignored", d, 8'h10);
        wr_ix(7'h0D, 8'h00);
        rd_ix(7'h0D, d); chk("R3 status write ignored", d, 8'h80);
    endtask

    task automatic t_no_enable();
        wr_ix(7'h0B, 8'h00);
        pulse(1, 0, 0);
        chk("R6 no irq when disabled", {7'b0, irq}, 8'h00);
        rd_ix(7'h0C, d); chk("R5 periodic bit 6", d, 8'h40);
        rd_ix(7'h0C, d); chk("R4 cleared", d, 8'h00);
    endtask

    task automatic t_enabled_event();
        wr_ix(7'h0B, 8'h20);
        pulse(0, 1, 0);
        chk("R6 alarm enabled irq", {7'b0, irq}, 8'h01);
        wr(0, 8'h0C); rd(1, d);
        chk("R4 read value", d, 8'hA0);
        chk("R4 irq drops", {7'b0, irq}, 8'h00);
        rd(1, d); chk("R4 flags zero", d, 8'h00);
    endtask

    task automatic t_enable_pending();
        wr_ix(7'h0B, 8'h00);
        pulse(0, 0, 1);
        chk("R6 update disabled", {7'b0, irq}, 8'h00);
        wr_ix(7'h0B, 8'h10);
        chk("R7 enable pending raises", {7'b0, irq}, 8'h01);
        wr_ix(7'h0B, 8'h40);
        chk("R7 other enable clears", {7'b0, irq}, 8'h00);
        rd_ix(7'h0C, d); chk("R7 flag kept", d, 8'h10);
        pulse(0, 0, 1);
        wr_ix(7'h0B, 8'h50);
        pulse(0, 0, 1);
        wr_ix(7'h0B, 8'h40);
        pulse(0, 0, 1);
        chk("R6 repeat of pending flag", {7'b0, irq}, 8'h00);
        rd_ix(7'h0C, d);
    endtask

    task automatic t_collide();
        wr_ix(7'h0B, 8'h20);
        pulse(0, 1, 0);
        wr(0, 8'h0C);
        @(negedge clk);
        bus_en = 1; bus_wr = 0; bus_odd = 1; evt_alarm = 1;
        #1 d = bus_rdata;
        @(posedge clk); #1 bus_en = 0; evt_alarm = 0;
        chk("R11 old value returned", d, 8'hA0);
        chk("R11 irq from fresh event", {7'b0, irq}, 8'h01);
        rd(1, d); chk("R11 event kept", d, 8'hA0);
    endtask

    task automatic t_warm();
        wr_ix(7'h0B, 8'h7A);
        pulse(1, 0, 0);
        wr_ix(7'h0F, 8'hFE); wr_ix(7'h21, 8'h77);
        warm();
        chk("R9 irq low", {7'b0, irq}, 8'h00);
        rd_ix(7'h0B, d); chk("R9 enables", d, 8'h12);
        rd_ix(7'h0C, d); chk("R9 flags", d, 8'h00);
        rd_ix(7'h0F, d); chk("R10 FE kept", d, 8'hFE);
        rd_ix(7'h21, d); chk("R10 other byte kept", d, 8'h77);
        wr_ix(7'h0F, 8'h33);
        warm();
        rd_ix(7'h0F, d); chk("R10 byte cleared", d, 8'h00);
    endtask

    initial begin
        #(20 * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_powerup();
        t_index();
        t_storage();
        t_readonly();
        t_no_enable();
        t_enabled_event();
        t_enable_pending();
        t_collide();
        t_warm();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule